// File: doc/BRIEF.md
# Parallel CRC-32 Frame Checksum Engine

This block computes the Ethernet CRC-32 of a frame that arrives as a stream of 16-byte words. It accepts one word on every clock cycle and never stalls. Inside each word, byte lane `i` (`in_data[8*i+7:8*i]`) is the `i`-th byte of that word in frame order. The running 32-bit remainder is folded into the leading bytes of each word. Every byte lane then addresses its own constant table of 256 precomputed remainders. The sixteen table outputs are XORed together to give the next remainder.

A frame may have any length. On the last word, a byte count says how many lanes hold frame bytes. The engine shifts those bytes up against the top lane, so that the same fixed set of tables gives the correct remainder for a short word. The bytes pushed out of range are discarded.

A small controller has two states:
- `ST_IDLE`: waiting for a frame.
- `ST_FRAME`: inside a frame.

It has these transitions:
- `ST_IDLE -> ST_FRAME` on an accepted start word without end.
- `ST_FRAME -> ST_IDLE` on any accepted end word.
- `ST_FRAME -> ST_FRAME` on an accepted word without end; this includes a start word, which restarts the frame.
- `ST_IDLE -> ST_IDLE` otherwise. This covers a start-and-end word, which is a complete frame in one cycle.

The result register and the done pulse are written by the same clock edge that accepts the end word.

Top module: `crc32_stream_engine`

## Requirements
- R1: The result is the reflected CRC-32 with polynomial 0xEDB88320, preset to 0xFFFFFFFF and inverted on output. The nine ASCII bytes "123456789" give 0xCBF43926.
- R2: One full 16-byte word is accepted on every cycle in which `in_valid` is high and a frame is open (or `in_sof` is high). Cycles with `in_valid` low are ignored, whatever the other inputs carry.
- R3: On an end word, `in_nbytes` = n (1..15) means lanes 0..n-1 are frame bytes, and lanes n..15 have no effect. A value of 0 or of 16..31 means all 16 lanes are frame bytes. On words without `in_eof`, `in_nbytes` is ignored.
- R4: A word with `in_sof` and `in_eof` both high is a complete frame and yields its correct CRC.
- R5: `crc_done` is high for exactly the one cycle after the clock edge that accepts an end word. `crc_out` changes only on that edge and holds until the next result.
- R6: A new frame may start on the word directly after an end word, with no idle cycle. Each frame still yields its own correct CRC.
- R7: In `ST_IDLE`, valid words without `in_sof` are ignored. They raise no `crc_done`, leave `crc_out` unchanged and do not open a frame.
- R8: A start word inside an open frame discards the partial frame and starts a new one from the preset.
- R9: During and right after reset, `crc_done` is 0, `crc_out` is 0 and the controller is in `ST_IDLE`.
- R10: A frame followed by its own CRC, sent least significant byte first, gives the constant 0x2144DF1C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Word on `in_data` is present this cycle |
| in_sof | input | 1 | Word is the first of a frame |
| in_eof | input | 1 | Word is the last of a frame |
| in_nbytes | input | 5 | Frame-byte count of the end word (0 or >15 = all 16) |
| in_data | input | 128 | Frame bytes, lane i = bits 8i+7..8i |
| crc_out | output | 32 | Registered CRC of the last completed frame |
| crc_done | output | 1 | One-cycle pulse: `crc_out` holds a new result |

## Verification
The bench compares the result against a bit-serial reference for frame lengths that cover every final-word size from 1 to 16. It fills the unused lanes with junk; a design that let those bytes reach the tables would produce wrong CRCs only for short final words.

Gap cycles carry a raised end flag with the valid flag low. A design that skipped the valid qualifier would end frames early.

Several other cases are driven as well:
- back-to-back frames, which catch a remainder that is not re-preset;
- restarted frames;
- stray idle words, which a design might wrongly start a frame on;
- a zero byte count, which a design might misread as a zero-length word;
- the good-frame residue, which catches a wrong output inversion or byte order.

// File: rtl/crc32_pkg.sv
package crc32_pkg;

    localparam int CRC_W = 32;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_FRAME = 1'b1
    } eng_state_e;

    // 256 remainders of 32 bits each, one table per byte lane
    typedef logic [255:0][CRC_W-1:0] crc_tbl_t;

    // Remainder of a single byte x followed by `zeros` zero bytes,
    // reflected algorithm, zero preset, no output inversion.
    function automatic crc_tbl_t build_table(input logic [CRC_W-1:0] poly,
                                             input int zeros);
        crc_tbl_t t;
        for (int x = 0; x < 256; x++) begin
            logic [CRC_W-1:0] r;
            r = CRC_W'(x);
            for (int z = 0; z <= zeros; z++) begin
                for (int b = 0; b < 8; b++) begin
                    r = r[0] ? ((r >> 1) ^ poly) : (r >> 1);
                end
            end
            t[x] = r;
        end
        return t;
    endfunction

endpackage

// File: rtl/crc32_byte_table.sv
module crc32_byte_table
    import crc32_pkg::*;
#(
    parameter logic [CRC_W-1:0] POLY  = 32'hEDB88320,
    parameter int               ZEROS = 0
) (
    input  logic [7:0]       idx,
    output logic [CRC_W-1:0] val
);
    localparam crc_tbl_t TBL = build_table(POLY, ZEROS);

    assign val = TBL[idx];
endmodule

// File: rtl/crc32_align.sv
module crc32_align
    import crc32_pkg::*;
#(
    parameter int DATA_BYTES = 16,
    localparam int DW  = 8 * DATA_BYTES,
    localparam int SHW = $clog2(DATA_BYTES)
) (
    input  logic [DW-1:0]       word,
    input  logic [CRC_W-1:0]    remainder,
    input  logic [SHW-1:0]      shift_bytes,
    output logic [DW+CRC_W-1:0] merged
);
    logic [DW-1:0]       data_up;
    logic [DW+CRC_W-1:0] rem_up;
    logic [SHW+2:0]      shift_bits;

    // The upward shift drops the unused lanes off the top of the word.
    // The leading zero bytes left behind keep a zero remainder at zero,
    // so the fixed table set still fits a short word.
    always_comb begin
        shift_bits = {shift_bytes, 3'b000};
        data_up    = word << shift_bits;
        rem_up     = {{DW{1'b0}}, remainder} << shift_bits;
        merged     = {{CRC_W{1'b0}}, data_up} ^ rem_up;
    end
endmodule

// File: rtl/crc32_fold.sv
module crc32_fold
    import crc32_pkg::*;
#(
    parameter int               DATA_BYTES = 16,
    parameter logic [CRC_W-1:0] POLY       = 32'hEDB88320,
    localparam int DW = 8 * DATA_BYTES
) (
    input  logic [DW+CRC_W-1:0] merged,
    output logic [CRC_W-1:0]    next_rem
);
    logic [DATA_BYTES-1:0][CRC_W-1:0] lane_val;

    for (genvar g = 0; g < DATA_BYTES; g++) begin : g_lane
        crc32_byte_table #(
            .POLY (POLY),
            .ZEROS(DATA_BYTES - 1 - g)
        ) u_tbl (
            .idx(merged[8*g +: 8]),
            .val(lane_val[g])
        );
    end

    // Bytes of the remainder that land above the word (final words
    // shorter than four bytes) pass straight through.
    always_comb begin
        next_rem = merged[DW +: CRC_W];
        for (int i = 0; i < DATA_BYTES; i++) begin
            next_rem = next_rem ^ lane_val[i];
        end
    end
endmodule

// File: rtl/crc32_stream_engine.sv
module crc32_stream_engine
    import crc32_pkg::*;
#(
    parameter int               DATA_BYTES = 16,
    parameter logic [CRC_W-1:0] POLY       = 32'hEDB88320,
    parameter logic [CRC_W-1:0] PRESET     = 32'hFFFFFFFF,
    parameter logic [CRC_W-1:0] OUT_XOR    = 32'hFFFFFFFF,
    localparam int DW    = 8 * DATA_BYTES,
    localparam int CNT_W = $clog2(DATA_BYTES) + 1,
    localparam int SHW   = $clog2(DATA_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic             in_eof,
    input  logic [CNT_W-1:0] in_nbytes,
    input  logic [DW-1:0]    in_data,
    output logic [CRC_W-1:0] crc_out,
    output logic             crc_done
);
    eng_state_e          state_q, state_d;
    logic [CRC_W-1:0]    rem_q;
    logic [CRC_W-1:0]    rem_in;
    logic [CRC_W-1:0]    rem_next;
    logic [CNT_W-1:0]    n_eff;
    logic [SHW-1:0]      shift_bytes;
    logic [DW+CRC_W-1:0] merged;
    logic                accept;

    // A word counts when a frame is open or the word opens one
    assign accept = in_valid && (in_sof || state_q == ST_FRAME);
    assign rem_in = in_sof ? PRESET : rem_q;

    always_comb begin
        n_eff = CNT_W'(DATA_BYTES);
        if (in_eof && in_nbytes != '0 && in_nbytes < CNT_W'(DATA_BYTES)) begin
            n_eff = in_nbytes;
        end
        shift_bytes = SHW'(CNT_W'(DATA_BYTES) - n_eff);
    end

    crc32_align #(
        .DATA_BYTES(DATA_BYTES)
    ) u_align (
        .word       (in_data),
        .remainder  (rem_in),
        .shift_bytes(shift_bytes),
        .merged     (merged)
    );

    crc32_fold #(
        .DATA_BYTES(DATA_BYTES),
        .POLY      (POLY)
    ) u_fold (
        .merged  (merged),
        .next_rem(rem_next)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (in_valid && in_sof && !in_eof) begin
                    state_d = ST_FRAME;
                end
            end
            ST_FRAME: begin
                if (in_valid && in_eof) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Running remainder and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q    <= PRESET;
            crc_out  <= '0;
            crc_done <= 1'b0;
        end else begin
            crc_done <= 1'b0;
            if (accept) begin
                rem_q <= rem_next;
                if (in_eof) begin
                    crc_out  <= rem_next ^ OUT_XOR;
                    crc_done <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/crc32_engine_chk.sv
module crc32_engine_chk
    import crc32_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_sof,
    input logic             in_eof,
    input logic [CRC_W-1:0] crc_out,
    input logic             crc_done,
    input eng_state_e       state_q
);
    AST_DONE_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_eof && (in_sof || state_q == ST_FRAME) |=> crc_done); // R5

    AST_DONE_NEEDS_END: assert property (@(posedge clk) disable iff (!rst_n)
        crc_done |-> $past(in_valid && in_eof)); // R5

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !crc_done |-> $stable(crc_out)); // R5

    AST_IDLE_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_IDLE && !in_sof |=> state_q == ST_IDLE && !crc_done); // R7

    AST_GAP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !crc_done && $stable(state_q)); // R2

    AST_START_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_sof && !in_eof |=> state_q == ST_FRAME); // R8

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !crc_done && state_q == ST_IDLE); // R9
endmodule

bind crc32_stream_engine crc32_engine_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_valid(in_valid),
    .in_sof  (in_sof),
    .in_eof  (in_eof),
    .crc_out (crc_out),
    .crc_done(crc_done),
    .state_q (state_q)
);

// File: tb/test_crc32_stream_engine.sv
`timescale 1ns/1ps
module test_crc32_stream_engine;
    localparam int DB = 16;

    typedef struct packed {
        int len;
        int seed;
        int gap;
    } vec_t;

    // Lengths 1..16 give every final-word size; longer ones add history
    localparam vec_t VECS [24] = '{
        '{1, 3, 0},   '{2, 5, 0},   '{3, 7, 1},   '{4, 9, 0},
        '{5, 11, 0},  '{6, 13, 0},  '{7, 15, 0},  '{8, 17, 0},
        '{9, 19, 0},  '{10, 21, 0}, '{11, 23, 0}, '{12, 25, 0},
        '{13, 27, 0}, '{14, 29, 0}, '{15, 31, 0}, '{16, 33, 0},
        '{17, 35, 1}, '{18, 37, 0}, '{35, 39, 1}, '{47, 41, 0},
        '{64, 43, 1}, '{77, 45, 0}, '{130, 47, 1}, '{255, 49, 0}
    };

    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid, in_sof, in_eof;
    logic [4:0]   in_nbytes;
    logic [127:0] in_data;
    logic [31:0]  crc_out;
    logic         crc_done;

    int           n_checks = 0;
    int           n_fail   = 0;
    bit           finished = 1'b0;
    logic [7:0]   fb [0:511];

    always #2.5 clk = ~clk;

    crc32_stream_engine i_crc32_stream_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_sof   (in_sof),
        .in_eof   (in_eof),
        .in_nbytes(in_nbytes),
        .in_data  (in_data),
        .crc_out  (crc_out),
        .crc_done (crc_done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_crc(input int len);
        logic [31:0] c;
        c = 32'hFFFFFFFF;
        for (int i = 0; i < len; i++) begin
            c = c ^ {24'd0, fb[i]};
            for (int b = 0; b < 8; b++) begin
                c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
            end
        end
        return ~c;
    endfunction

    task automatic fill(input int len, input int seed);
        logic [31:0] s;
        s = 32'(seed) * 32'd2654435761;
        for (int i = 0; i < len; i++) begin
            s = s * 32'd1103515245 + 32'd12345;
            fb[i] = s[23:16];
        end
    endtask

    task automatic drive_idle();
        in_valid  = 1'b0;
        in_sof    = 1'b0;
        in_eof    = 1'b0;
        in_nbytes = 5'd0;
        in_data   = {4{32'hDEADBEEF}};
    endtask

    // Lanes beyond the frame carry junk on purpose (R3)
    task automatic put_word(input int w, input int len, input bit sof, input bit eof,
                            input bit zero_cnt);
        in_valid = 1'b1;
        in_sof   = sof;
        in_eof   = eof;
        for (int i = 0; i < DB; i++) begin
            int idx;
            idx = w * DB + i;
            in_data[8*i +: 8] = (idx < len) ? fb[idx] : (8'hC3 ^ 8'(idx));
        end
        if (eof) begin
            in_nbytes = (zero_cnt || len % DB == 0) ? (zero_cnt ? 5'd0 : 5'd16) : 5'(len % DB);
        end else begin
            in_nbytes = 5'd3;
        end
    endtask

    // Called and returns just after a falling edge
    task automatic send_frame(input int len, input int gap, input string req,
                              input bit zero_cnt);
        int          nw;
        logic [31:0] exp;
        exp = ref_crc(len);
        nw  = (len + DB - 1) / DB;
        for (int w = 0; w < nw; w++) begin
            put_word(w, len, w == 0, w == nw - 1, zero_cnt);
            @(negedge clk);
            if (w != nw - 1) begin
                chk({req, " R2 no done mid-frame"}, {31'd0, crc_done}, 32'd0);
                if (gap != 0) begin
                    drive_idle();
                    in_eof = 1'b1;
                    @(negedge clk);
                    chk({req, " R2 gap ignored"}, {31'd0, crc_done}, 32'd0);
                end
            end
        end
        chk({req, " R5 done"}, {31'd0, crc_done}, 32'd1);
        chk({req, " crc"}, crc_out, exp);
        drive_idle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] held;
        logic [31:0] c;
        drive_idle();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9 crc_out in reset", crc_out, 32'd0);
        chk("R9 done in reset", {31'd0, crc_done}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 crc_out after reset", crc_out, 32'd0);
        chk("R9 done after reset", {31'd0, crc_done}, 32'd0);

        // R1 / R4: check string in one word
        for (int i = 0; i < 9; i++) fb[i] = 8'h31 + 8'(i);
        send_frame(9, 0, "R1 R4 check string", 1'b0);
        chk("R1 check value", crc_out, 32'hCBF43926);

        // Vector table walk: every final-word size, with gaps (R3)
        foreach (VECS[k]) begin
            fill(VECS[k].len, VECS[k].seed);
            send_frame(VECS[k].len, VECS[k].gap, "R3 vector", 1'b0);
            held = crc_out;
            @(negedge clk);
            chk("R5 single pulse", {31'd0, crc_done}, 32'd0);
            chk("R5 result held", crc_out, held);
        end

        // R10: residue of frames carrying their own FCS
        fill(60, 77);
        c = ref_crc(60);
        for (int i = 0; i < 4; i++) fb[60 + i] = c[8*i +: 8];
        send_frame(64, 0, "R10 residue 64", 1'b0);
        chk("R10 residue value 64", crc_out, 32'h2144DF1C);
        fill(13, 78);
        c = ref_crc(13);
        for (int i = 0; i < 4; i++) fb[13 + i] = c[8*i +: 8];
        send_frame(17, 1, "R10 residue 17", 1'b0);
        chk("R10 residue value 17", crc_out, 32'h2144DF1C);

        // R7: stray words while idle
        held = crc_out;
        fill(20, 5);
        for (int w = 0; w < 3; w++) begin
            put_word(0, 20, 1'b0, 1'b1, 1'b0);
            @(negedge clk);
            chk("R7 idle no done", {31'd0, crc_done}, 32'd0);
            chk("R7 idle crc held", crc_out, held);
        end
        drive_idle();
        send_frame(20, 0, "R7 frame after stray", 1'b0);

        // R8: restart an open frame
        fill(40, 91);
        put_word(0, 40, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        put_word(1, 40, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        chk("R8 partial no done", {31'd0, crc_done}, 32'd0);
        fill(23, 92);
        send_frame(23, 0, "R8 restarted", 1'b0);

        // R6: back-to-back frames, no idle cycle
        fill(17, 101);
        send_frame(17, 0, "R6 first", 1'b0);
        fill(16, 102);
        send_frame(16, 0, "R6 second", 1'b0);
        fill(1, 103);
        send_frame(1, 0, "R6 third", 1'b0);
        fill(33, 104);
        send_frame(33, 0, "R6 fourth", 1'b0);

        // R3: count 0 on the end word means a full word
        fill(32, 111);
        send_frame(32, 0, "R3 zero count", 1'b1);

        @(negedge clk);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule